// File: doc/BRIEF.md
# Exception Control Register Unit

This unit is the system-control register bank that a simple in-order processor uses to record exceptions and interrupts. When the pipeline raises an exception request, the unit captures the PC of the interrupted instruction and the exception code. If the exception is an address fault, it also captures the faulting virtual address. It then pushes a three-deep stack of interrupt-enable / kernel-user pairs and sends a one-cycle redirect to the fetch stage, pointing at a fixed handler vector.

A return-from-exception command pops the stack in one cycle, so the enable bit and the mode bit are restored together. Hardware interrupt lines are held as sticky pending bits until the handler acknowledges them. The unit combines the pending bits with a mask held in Status and with the current enable bit, and drives an interrupt-take signal. Software reads and writes the registers by register number.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After synchronous reset, every mapped register reads zero, and irq_take and redirect_valid are low.
- R2: Reads are combinational, by register number: 8 = bad virtual address, 12 = Status, 13 = Cause, 14 = exception PC. Any other number reads zero. Only Status is writable. A Status write is visible after the next clock edge, and a write to 8, 13 or 14 has no effect. Status layout: bit 0 is the current IE bit, bit 1 the current KU bit (0 = kernel), bits [3:2] the previous pair, bits [5:4] the old pair, bits [12:8] the interrupt mask. All other bits read 0.
- R3: On an exception request, Status[5:0] becomes {Status[3:0], 2'b00}. This means kernel mode with interrupts disabled. The mask is unchanged.
- R4: On return-from-exception, Status[3:0] takes the old Status[5:2], and Status[5:4] keeps its value. The mask is unchanged.
- R5: On an exception request, the exception PC register takes exc_pc and Cause[5:2] takes exc_code.
- R6: The bad-address register takes exc_bad_va only when exc_req and exc_addr_fault are both high. Otherwise it holds its value.
- R7: Cause[15:11] holds pending bits, with bit 11+i set by irq_in[i]. A pending bit stays set until irq_ack[i] is high. If irq_in[i] and irq_ack[i] are high in the same cycle, the bit stays set.
- R8: irq_take is high exactly when some pending bit AND its mask bit is 1 and Status bit 0 (IE) is 1.
- R9: redirect_valid is high for one cycle, in the cycle after each cycle with exc_req high. redirect_pc is the vector parameter, by default 32'h8000_0080.
- R10: Same-cycle priority on Status is exception request, then return-from-exception, then software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception entry request |
| exc_code | input | 4 | Exception code to record |
| exc_pc | input | 32 | PC of interrupted instruction |
| exc_addr_fault | input | 1 | Exception is an address fault |
| exc_bad_va | input | 32 | Faulting virtual address |
| rfe | input | 1 | Return-from-exception command |
| irq_in | input | 5 | Hardware interrupt lines |
| irq_ack | input | 5 | Clears serviced pending bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_take | output | 1 | An enabled, unmasked interrupt is pending |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Handler vector address |

## Verification
The enable/mode stack is checked with all 64 starting values. Each value is pushed and then popped, and each value is also popped directly. This separates a correct shift from a dropped or duplicated pair, and it shows whether the old pair is kept on return. Interrupt take is checked over every pending, mask and enable combination (2048 cases), which exposes a missing term in the three-way AND. Directed cases cover the remaining behaviour:
- all 16 exception codes, each with a distinct PC;
- fault-gated bad-address capture;
- sticky and acknowledged pending bits, including set and acknowledge in the same cycle;
- writes to read-only and unmapped registers;
- each pairwise collision of exception, return and write.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
    localparam int XLEN      = 32;
    localparam int IRQ_N     = 5;
    localparam int CODE_W    = 4;
    localparam int REGNUM_W  = 5;
    localparam int PAIR_W    = 2;
    localparam int STK_W     = 3 * PAIR_W;
    localparam int ST_MASK_LSB = 8;
    localparam int CA_CODE_LSB = 2;
    localparam int CA_PEND_LSB = 11;

    localparam logic [REGNUM_W-1:0] RN_BADVA  = REGNUM_W'(8);
    localparam logic [REGNUM_W-1:0] RN_STATUS = REGNUM_W'(12);
    localparam logic [REGNUM_W-1:0] RN_CAUSE  = REGNUM_W'(13);
    localparam logic [REGNUM_W-1:0] RN_EPC    = REGNUM_W'(14);

    // each pair: bit 0 = interrupt enable, bit 1 = kernel/user (0 = kernel)
    typedef struct packed {
        logic [PAIR_W-1:0] old_p;
        logic [PAIR_W-1:0] prev_p;
        logic [PAIR_W-1:0] cur_p;
    } ieku_stack_t;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_LOAD
    } stk_op_e;

    function automatic ieku_stack_t stk_push(ieku_stack_t s);
        ieku_stack_t n;
        n.old_p  = s.prev_p;
        n.prev_p = s.cur_p;
        n.cur_p  = '0;
        return n;
    endfunction

    function automatic ieku_stack_t stk_pop(ieku_stack_t s);
        ieku_stack_t n;
        n.old_p  = s.old_p;
        n.prev_p = s.old_p;
        n.cur_p  = s.prev_p;
        return n;
    endfunction

    function automatic logic [XLEN-1:0] pack_status(ieku_stack_t s, logic [IRQ_N-1:0] m);
        logic [XLEN-1:0] w;
        w = '0;
        w[STK_W-1:0] = s;
        w[ST_MASK_LSB +: IRQ_N] = m;
        return w;
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(logic [CODE_W-1:0] c, logic [IRQ_N-1:0] p);
        logic [XLEN-1:0] w;
        w = '0;
        w[CA_CODE_LSB +: CODE_W] = c;
        w[CA_PEND_LSB +: IRQ_N]  = p;
        return w;
    endfunction
endpackage

// File: rtl/exc_status_stack.sv
`timescale 1ns/1ps
module exc_status_stack
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [STK_W-1:0]  ld_stack,
    input  logic [IRQ_N-1:0]  ld_mask,
    output ieku_stack_t       stack_q,
    output logic [IRQ_N-1:0]  mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stack_q <= '0;
            mask_q  <= '0;
        end else begin
            case (op)
                STK_PUSH: stack_q <= stk_push(stack_q);
                STK_POP:  stack_q <= stk_pop(stack_q);
                STK_LOAD: begin
                    stack_q <= ieku_stack_t'(ld_stack);
                    mask_q  <= ld_mask;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_cause_unit.sv
`timescale 1ns/1ps
module exc_cause_unit
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [IRQ_N-1:0]  irq_in,
    input  logic [IRQ_N-1:0]  irq_ack,
    output logic [CODE_W-1:0] code_q,
    output logic [IRQ_N-1:0]  pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            pend_q <= '0;
        end else begin
            if (exc_req) code_q <= exc_code;
            pend_q <= (pend_q & ~irq_ack) | irq_in;
        end
    end
endmodule

// File: rtl/exc_capture.sv
`timescale 1ns/1ps
module exc_capture
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_req,
    input  logic [XLEN-1:0] exc_pc,
    input  logic            addr_fault,
    input  logic [XLEN-1:0] bad_va,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] badva_q,
    output logic            redirect_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q      <= '0;
            badva_q    <= '0;
            redirect_q <= 1'b0;
        end else begin
            redirect_q <= exc_req;
            if (exc_req) begin
                epc_q <= exc_pc;
                if (addr_fault) badva_q <= bad_va;
            end
        end
    end
endmodule

// File: rtl/exc_ctrl_regs.sv
`timescale 1ns/1ps
module exc_ctrl_regs
    import exc_pkg::*;
#(
    parameter logic [31:0] VECTOR_PC = 32'h8000_0080
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                exc_req,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic [XLEN-1:0]     exc_pc,
    input  logic                exc_addr_fault,
    input  logic [XLEN-1:0]     exc_bad_va,
    input  logic                rfe,
    input  logic [IRQ_N-1:0]    irq_in,
    input  logic [IRQ_N-1:0]    irq_ack,
    input  logic                reg_wr,
    input  logic [REGNUM_W-1:0] reg_addr,
    input  logic [XLEN-1:0]     reg_wdata,
    output logic [XLEN-1:0]     reg_rdata,
    output logic                irq_take,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc
);
    stk_op_e           stk_op;
    ieku_stack_t       stack_q;
    logic [IRQ_N-1:0]  mask_q;
    logic [CODE_W-1:0] code_q;
    logic [IRQ_N-1:0]  pend_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   badva_q;
    logic              redirect_q;

    // exception entry beats return, return beats software write
    always_comb begin
        if (exc_req)                             stk_op = STK_PUSH;
        else if (rfe)                            stk_op = STK_POP;
        else if (reg_wr && reg_addr == RN_STATUS) stk_op = STK_LOAD;
        else                                     stk_op = STK_HOLD;
    end

    exc_status_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (stk_op),
        .ld_stack (reg_wdata[STK_W-1:0]),
        .ld_mask  (reg_wdata[ST_MASK_LSB +: IRQ_N]),
        .stack_q  (stack_q),
        .mask_q   (mask_q)
    );

    exc_cause_unit u_cause (
        .clk      (clk),
        .rst      (rst),
        .exc_req  (exc_req),
        .exc_code (exc_code),
        .irq_in   (irq_in),
        .irq_ack  (irq_ack),
        .code_q   (code_q),
        .pend_q   (pend_q)
    );

    exc_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .exc_req    (exc_req),
        .exc_pc     (exc_pc),
        .addr_fault (exc_addr_fault),
        .bad_va     (exc_bad_va),
        .epc_q      (epc_q),
        .badva_q    (badva_q),
        .redirect_q (redirect_q)
    );

    always_comb begin
        case (reg_addr)
            RN_BADVA:  reg_rdata = badva_q;
            RN_STATUS: reg_rdata = pack_status(stack_q, mask_q);
            RN_CAUSE:  reg_rdata = pack_cause(code_q, pend_q);
            RN_EPC:    reg_rdata = epc_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_take       = (|(pend_q & mask_q)) & stack_q.cur_p[0];
    assign redirect_valid = redirect_q;
    assign redirect_pc    = VECTOR_PC;
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
`timescale 1ns/1ps
module exc_ctrl_regs_chk
    import exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exc_req,
    input logic              rfe,
    input logic [XLEN-1:0]   exc_pc,
    input logic [IRQ_N-1:0]  irq_ack,
    input logic [STK_W-1:0]  stk,
    input logic [IRQ_N-1:0]  mask,
    input logic [IRQ_N-1:0]  pend,
    input logic [XLEN-1:0]   epc,
    input logic              redirect_valid,
    input logic              irq_take
);
    AST_ENTRY_PUSH: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> stk == {$past(stk[3:0]), 2'b00}); // R3

    AST_RETURN_POP: assert property (@(posedge clk) disable iff (rst)
        (rfe && !exc_req) |=> (stk[3:0] == $past(stk[5:2]) && stk[5:4] == $past(stk[5:4]))); // R4

    AST_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (exc_req || rfe) |=> $stable(mask)); // R10

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> epc == $past(exc_pc)); // R5

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend) & ~$past(irq_ack) & ~pend) == '0)); // R7

    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> stk[0]); // R8

    AST_TAKE_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        ((pend & mask) == '0) |-> !irq_take); // R8

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> redirect_valid); // R9

    AST_REDIRECT_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        !exc_req |=> !redirect_valid); // R9
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .exc_req        (exc_req),
    .rfe            (rfe),
    .exc_pc         (exc_pc),
    .irq_ack        (irq_ack),
    .stk            (stack_q),
    .mask           (mask_q),
    .pend           (pend_q),
    .epc            (epc_q),
    .redirect_valid (redirect_valid),
    .irq_take       (irq_take)
);

// File: tb/test_exc_ctrl_regs.sv
`timescale 1ns/1ps
module test_exc_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req, exc_addr_fault, rfe, reg_wr;
    logic [3:0]  exc_code;
    logic [31:0] exc_pc, exc_bad_va, reg_wdata, reg_rdata, redirect_pc;
    logic [4:0]  irq_in, irq_ack, reg_addr;
    logic        irq_take, redirect_valid;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    exc_ctrl_regs i_exc_ctrl_regs (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_addr_fault(exc_addr_fault), .exc_bad_va(exc_bad_va),
        .rfe(rfe), .irq_in(irq_in), .irq_ack(irq_ack), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_take(irq_take), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic logic [31:0] m_push(logic [31:0] st);
        return (st & 32'h1F00) | ((st << 2) & 32'h3C);
    endfunction
    function automatic logic [31:0] m_pop(logic [31:0] st);
        return (st & 32'h1F30) | ((st >> 2) & 32'hF);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_in();
        exc_req = 0; exc_addr_fault = 0; rfe = 0; reg_wr = 0;
        irq_in = '0; irq_ack = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        clear_in();
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wr_status(input logic [31:0] v);
        reg_wr = 1; reg_addr = 5'd12; reg_wdata = v;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st, exp_st;
        clear_in();
        exc_code = 0; exc_pc = 0; exc_bad_va = 0; reg_addr = 0; reg_wdata = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        rd(5'd8, v);  chk("R1 badva", v, 0);
        rd(5'd12, v); chk("R1 status", v, 0);
        rd(5'd13, v); chk("R1 cause", v, 0);
        rd(5'd14, v); chk("R1 epc", v, 0);
        chk("R1 irq_take", {31'b0, irq_take}, 0);
        chk("R1 redirect_valid", {31'b0, redirect_valid}, 0);

        // R2 write layout and next-cycle visibility
        reg_wr = 1; reg_addr = 5'd12; reg_wdata = 32'hFFFF_FFFF; #1;
        chk("R2 write not yet visible", reg_rdata, 0);
        step();
        rd(5'd12, v); chk("R2 status writable bits", v, 32'h0000_1F3F);

        // R3/R4 exhaustive stack sweep
        for (int s = 0; s < 64; s++) begin
            st = 32'h1500 | s;
            wr_status(st);
            rd(5'd12, v); chk("R2 status readback", v, st);
            exc_req = 1; exc_code = 4'(s); exc_pc = 32'h100 + 32'(s);
            step();
            exp_st = m_push(st);
            rd(5'd12, v); chk("R3 push", v, exp_st);
            rfe = 1;
            step();
            rd(5'd12, v); chk("R4 pop after push", v, m_pop(exp_st));
            wr_status(st);
            rfe = 1;
            step();
            rd(5'd12, v); chk("R4 pop direct", v, m_pop(st));
        end

        // R5/R9 code and PC capture sweep
        for (int c = 0; c < 16; c++) begin
            exc_req = 1; exc_code = 4'(c);
            exc_pc = 32'h0040_0000 + 32'(c * 4) + (32'(c) << 20);
            step();
            chk("R9 redirect strobe", {31'b0, redirect_valid}, 1);
            chk("R9 redirect vector", redirect_pc, 32'h8000_0080);
            rd(5'd13, v); chk("R5 cause code", v, 32'(c) << 2);
            rd(5'd14, v); chk("R5 epc", v, 32'h0040_0000 + 32'(c * 4) + (32'(c) << 20));
            step();
            chk("R9 strobe one cycle", {31'b0, redirect_valid}, 0);
        end

        // R6 bad address gating
        exc_req = 1; exc_addr_fault = 1; exc_bad_va = 32'h1234_5678;
        step();
        rd(5'd8, v); chk("R6 latch on fault", v, 32'h1234_5678);
        exc_req = 1; exc_addr_fault = 0; exc_bad_va = 32'hAAAA_5555;
        step();
        rd(5'd8, v); chk("R6 hold without fault", v, 32'h1234_5678);
        exc_addr_fault = 1; exc_bad_va = 32'h5555_AAAA;
        step();
        rd(5'd8, v); chk("R6 hold without request", v, 32'h1234_5678);

        // R2 read-only and unmapped registers
        rd(5'd14, st);
        reg_wr = 1; reg_addr = 5'd8;  reg_wdata = 32'hDEAD_BEEF; step();
        reg_wr = 1; reg_addr = 5'd13; reg_wdata = 32'hDEAD_BEEF; step();
        reg_wr = 1; reg_addr = 5'd14; reg_wdata = 32'hDEAD_BEEF; step();
        rd(5'd8, v);  chk("R2 badva read-only", v, 32'h1234_5678);
        rd(5'd13, v); chk("R2 cause read-only", v, 32'(4'hF) << 2 & 32'h3C);
        rd(5'd14, v); chk("R2 epc read-only", v, st);
        rd(5'd0, v);  chk("R2 unmapped 0", v, 0);
        rd(5'd9, v);  chk("R2 unmapped 9", v, 0);
        rd(5'd31, v); chk("R2 unmapped 31", v, 0);

        // R7 sticky pending bits
        irq_in = 5'b10101; step();
        step(); step();
        rd(5'd13, v); chk("R7 pending sticky", v[15:11], 5'b10101);
        irq_ack = 5'b00001; step();
        rd(5'd13, v); chk("R7 ack clears", v[15:11], 5'b10100);
        irq_in = 5'b00010; irq_ack = 5'b00010; step();
        rd(5'd13, v); chk("R7 set wins over ack", v[15:11], 5'b10110);
        irq_ack = 5'b11111; step();
        rd(5'd13, v); chk("R7 ack all", v[15:11], 0);

        // R8 exhaustive take sweep
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 32; m++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    irq_in = 5'(p);
                    wr_status((32'(m) << 8) | 32'(ie));
                    chk("R8 irq_take", {31'b0, irq_take},
                        {31'b0, ((p & m) != 0) && (ie == 1)});
                    irq_ack = 5'b11111; step();
                end
            end
        end

        // R10 collisions
        wr_status(32'h0000_0107);
        exc_req = 1; rfe = 1; step();
        rd(5'd12, v); chk("R10 exception over return", v, m_push(32'h107));
        wr_status(32'h0000_0107);
        exc_req = 1; reg_wr = 1; reg_addr = 5'd12; reg_wdata = 32'h0000_1F3F; step();
        rd(5'd12, v); chk("R10 exception over write", v, m_push(32'h107));
        wr_status(32'h0000_0236);
        rfe = 1; reg_wr = 1; reg_addr = 5'd12; reg_wdata = 32'h0000_0001; step();
        rd(5'd12, v); chk("R10 return over write", v, m_pop(32'h236));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule